// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block keeps a record of the memory requests a nonblocking cache currently has in flight, whether they are demand reads, write misses or prefetches. Every incoming request is compared by block address against all live entries. When no live entry covers the same block and a free slot exists, the request is accepted. It takes the lowest free slot, and one cycle later it is sent to memory carrying that slot number as its tag. When a live entry already covers the block, or the table is full, the request port holds ready low and the request waits.

The memory side answers with a tag, in any order. A reply naming a live entry frees that slot and, one cycle later, reports the block address and the request kind that were stored there. A reply naming an empty slot changes nothing and raises a one-cycle error pulse. The low address bits that select a byte inside a block take no part in any comparison, and the addresses sent to memory and reported on release have those bits cleared.

Top module: `miss_track_table`

## Requirements
- R1: After reset every slot is empty, `reqReady` is high, and `memValid`, `doneValid` and `rspErr` are low.
- R2: A request accepted at a clock edge (`reqValid` and `reqReady` both high) drives `memValid` high for exactly the following cycle. In that cycle `memAddr` is the request address with its offset bits zeroed and `memKind` is the request kind. Kind encoding: 0 read, 1 write, 2 read-prefetch, 3 write-prefetch.
- R3: An accepted request is given the lowest-numbered empty slot, and that slot number appears on `memTag`.
- R4: `reqReady` is low whenever any occupied slot holds the same block address as `reqAddr`, whatever the two kinds are. This includes a write-prefetch arriving while a write or write-prefetch to that block is outstanding.
- R5: `reqReady` is low while all ENTRIES slots are occupied.
- R6: A reply with `rspValid` high and a tag naming an occupied slot empties that slot at the edge. In the next cycle `doneValid` is high, with `doneTag`, `doneAddr` (offset zeroed) and `doneKind` taken from the slot.
- R7: Replies may arrive in any order relative to issue, and each one releases only the slot its tag names.
- R8: A reply whose tag names an empty slot raises `rspErr` for the next cycle, keeps `doneValid` low and leaves every slot unchanged.
- R9: An allocation and a release in the same cycle both take effect. The freed slot is not reused in that cycle.
- R10: Two addresses that differ only in the OFFSET_W low bits refer to the same block. Addresses in different blocks never conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqAddr | input | ADDR_W | Request byte address |
| reqKind | input | 2 | Request kind (0 rd, 1 wr, 2 rd-prefetch, 3 wr-prefetch) |
| memValid | output | 1 | Memory request strobe |
| memTag | output | TAG_W | Slot number carried with the memory request |
| memAddr | output | ADDR_W | Block-aligned memory request address |
| memKind | output | 2 | Kind of the memory request |
| rspValid | input | 1 | Memory reply present |
| rspTag | input | TAG_W | Tag carried by the reply |
| doneValid | output | 1 | A slot was released by the previous reply |
| doneTag | output | TAG_W | Released slot number |
| doneAddr | output | ADDR_W | Block-aligned address of the released slot |
| doneKind | output | 2 | Kind of the released slot |
| rspErr | output | 1 | Previous reply named an empty slot |

## Verification
Several properties are checked on every cycle. An accepted request is always followed by exactly one memory strobe, and a memory strobe never appears without one. The issued tag always names a slot that was empty. A full table never shows ready. A reply never produces a release and an error at once, and an error reply leaves the occupancy vector untouched. Other behaviours only show up in the bench's scenarios: which slot is chosen, the block-address conflict across different kinds and offsets, out-of-order release, and the reported address and kind. A cycle-by-cycle reference model checks these.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_PFR = 2'd2,
    KIND_PFW = 2'd3
  } reqKind_e;

  // control-to-datapath strobes for one cycle
  typedef struct packed {
    logic allocEn;
    logic freeEn;
    logic errEn;
  } strobe_s;

endpackage

// File: rtl/mtt_ctrl.sv
module mtt_ctrl
  import mtt_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int TAG_W = $clog2(ENTRIES)
) (
  input  logic               reqValid,
  input  logic               rspValid,
  input  logic [TAG_W-1:0]   rspTag,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] hitVec,
  output logic               reqReady,
  output strobe_s            strobe,
  output logic [TAG_W-1:0]   allocIdx,
  output logic [TAG_W-1:0]   freeIdx
);

  logic tableFull;
  logic blockBusy;

  assign tableFull = &validVec;
  assign blockBusy = |hitVec;
  assign reqReady  = !tableFull && !blockBusy;

  // lowest empty slot: scan from the top so the smallest index wins
  always_comb begin
    allocIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) allocIdx = TAG_W'(i);
    end
  end

  assign freeIdx        = rspTag;
  assign strobe.allocEn = reqValid && reqReady;
  assign strobe.freeEn  = rspValid && validVec[rspTag];
  assign strobe.errEn   = rspValid && !validVec[rspTag];

endmodule

// File: rtl/mtt_datapath.sv
module mtt_datapath
  import mtt_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  localparam int TAG_W = $clog2(ENTRIES),
  localparam int BLK_W = ADDR_W - OFFSET_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_s            strobe,
  input  logic [TAG_W-1:0]   allocIdx,
  input  logic [TAG_W-1:0]   freeIdx,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqKind,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] hitVec,
  output logic               memValid,
  output logic [TAG_W-1:0]   memTag,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [1:0]         memKind,
  output logic               doneValid,
  output logic [TAG_W-1:0]   doneTag,
  output logic [ADDR_W-1:0]  doneAddr,
  output logic [1:0]         doneKind,
  output logic               rspErr
);

  logic [BLK_W-1:0] reqBlk;
  logic [BLK_W-1:0] blkQ  [ENTRIES];
  logic [1:0]       kindQ [ENTRIES];

  assign reqBlk = reqAddr[ADDR_W-1:OFFSET_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic allocHere;
    logic freeHere;

    assign allocHere = strobe.allocEn && (allocIdx == TAG_W'(g));
    assign freeHere  = strobe.freeEn  && (freeIdx  == TAG_W'(g));
    assign hitVec[g] = validVec[g] && (blkQ[g] == reqBlk);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
      end else if (allocHere) begin
        validVec[g] <= 1'b1;
      end else if (freeHere) begin
        validVec[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (allocHere) begin
        blkQ[g]  <= reqBlk;
        kindQ[g] <= reqKind;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid  <= 1'b0;
      doneValid <= 1'b0;
      rspErr    <= 1'b0;
    end else begin
      memValid  <= strobe.allocEn;
      doneValid <= strobe.freeEn;
      rspErr    <= strobe.errEn;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.allocEn) begin
      memTag  <= allocIdx;
      memAddr <= {reqBlk, {OFFSET_W{1'b0}}};
      memKind <= reqKind;
    end
    if (strobe.freeEn) begin
      doneTag  <= freeIdx;
      doneAddr <= {blkQ[freeIdx], {OFFSET_W{1'b0}}};
      doneKind <= kindQ[freeIdx];
    end
  end

endmodule

// File: rtl/miss_track_table.sv
module miss_track_table
  import mtt_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  localparam int TAG_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  output logic              memValid,
  output logic [TAG_W-1:0]  memTag,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memKind,
  input  logic              rspValid,
  input  logic [TAG_W-1:0]  rspTag,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic [ADDR_W-1:0] doneAddr,
  output logic [1:0]        doneKind,
  output logic              rspErr
);

  strobe_s            strobe;
  logic [TAG_W-1:0]   allocIdx;
  logic [TAG_W-1:0]   freeIdx;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] hitVec;

  mtt_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .reqValid (reqValid),
    .rspValid (rspValid),
    .rspTag   (rspTag),
    .validVec (validVec),
    .hitVec   (hitVec),
    .reqReady (reqReady),
    .strobe   (strobe),
    .allocIdx (allocIdx),
    .freeIdx  (freeIdx)
  );

  mtt_datapath #(
    .ENTRIES  (ENTRIES),
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .allocIdx  (allocIdx),
    .freeIdx   (freeIdx),
    .reqAddr   (reqAddr),
    .reqKind   (reqKind),
    .validVec  (validVec),
    .hitVec    (hitVec),
    .memValid  (memValid),
    .memTag    (memTag),
    .memAddr   (memAddr),
    .memKind   (memKind),
    .doneValid (doneValid),
    .doneTag   (doneTag),
    .doneAddr  (doneAddr),
    .doneKind  (doneKind),
    .rspErr    (rspErr)
  );

endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               memValid,
  input logic [TAG_W-1:0]   memTag,
  input logic               doneValid,
  input logic               rspErr,
  input logic [ENTRIES-1:0] validVec
);

  logic [ENTRIES-1:0] prevValid;

  always_ff @(posedge clk) begin
    if (!rstN) prevValid <= '0;
    else       prevValid <= validVec;
  end

  a_r2_issue_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memValid);

  a_r2_no_spurious_issue: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !memValid);

  a_r3_tag_was_empty: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(rstN)) |-> !prevValid[memTag]);

  a_r5_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (&validVec) |-> !reqReady);

  a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && rspErr));

  a_r8_err_keeps_table: assert property (@(posedge clk) disable iff (!rstN)
    (rspErr && !memValid && $past(rstN)) |-> (validVec == prevValid));

endmodule

bind miss_track_table mtt_checker #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .memValid  (memValid),
  .memTag    (memTag),
  .doneValid (doneValid),
  .rspErr    (rspErr),
  .validVec  (validVec)
);

// File: tb/miss_track_table_tb.sv
module miss_track_table_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int AW  = 32;
  localparam int OW  = 6;
  localparam int TW  = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [AW-1:0] reqAddr;
  logic [1:0]    reqKind;
  logic          memValid;
  logic [TW-1:0] memTag;
  logic [AW-1:0] memAddr;
  logic [1:0]    memKind;
  logic          rspValid;
  logic [TW-1:0] rspTag;
  logic          doneValid;
  logic [TW-1:0] doneTag;
  logic [AW-1:0] doneAddr;
  logic [1:0]    doneKind;
  logic          rspErr;

  int checks   = 0;
  int failures = 0;

  // behavioural model of the table
  bit            mOcc  [N];
  logic [AW-1:0] mAddr [N];
  logic [1:0]    mKind [N];

  miss_track_table #(.ENTRIES(N), .ADDR_W(AW), .OFFSET_W(OW)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqKind(reqKind),
    .memValid(memValid), .memTag(memTag), .memAddr(memAddr), .memKind(memKind),
    .rspValid(rspValid), .rspTag(rspTag),
    .doneValid(doneValid), .doneTag(doneTag), .doneAddr(doneAddr), .doneKind(doneKind),
    .rspErr(rspErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] blkOf(input logic [AW-1:0] a);
    return {a[AW-1:OW], {OW{1'b0}}};
  endfunction

  // one cycle: drive inputs, check ready, advance model, check registered outputs
  task automatic step(input bit rv, input logic [AW-1:0] a, input logic [1:0] k,
                      input bit sv, input logic [TW-1:0] t, input string req);
    bit expReady, accept, freeOk, full, hit;
    int idx;
    logic [AW-1:0] relAddr;
    logic [1:0]    relKind;
    reqValid = rv; reqAddr = a; reqKind = k; rspValid = sv; rspTag = t;
    #1;
    full = 1'b1; hit = 1'b0; idx = -1;
    for (int i = 0; i < N; i++) begin
      if (!mOcc[i]) begin
        full = 1'b0;
        if (idx < 0) idx = i;
      end
      if (mOcc[i] && mAddr[i] == blkOf(a)) hit = 1'b1;
    end
    expReady = !full && !hit;
    chk(reqReady == expReady, {req, " ready"}, reqReady, expReady);
    accept = rv && expReady;
    freeOk = sv && mOcc[t];
    relAddr = mAddr[t];
    relKind = mKind[t];
    if (freeOk) mOcc[t] = 1'b0;
    if (accept) begin
      mOcc[idx]  = 1'b1;
      mAddr[idx] = blkOf(a);
      mKind[idx] = k;
    end
    @(negedge clk);
    chk(memValid == accept, {req, " memValid"}, memValid, accept);
    if (accept) begin
      chk(memTag == TW'(idx), "R3 memTag", memTag, idx);
      chk(memAddr == blkOf(a), "R2 memAddr", memAddr, blkOf(a));
      chk(memKind == k, "R2 memKind", memKind, k);
    end
    chk(doneValid == freeOk, {req, " doneValid"}, doneValid, freeOk);
    if (freeOk) begin
      chk(doneTag == t, "R6 doneTag", doneTag, t);
      chk(doneAddr == relAddr, "R6 doneAddr", doneAddr, relAddr);
      chk(doneKind == relKind, "R6 doneKind", doneKind, relKind);
    end
    chk(rspErr == (sv && !freeOk), "R8 rspErr", rspErr, sv && !freeOk);
  endtask

  function automatic logic [AW-1:0] blkAddr(input int n, input int off);
    return 32'h1000_0000 + AW'(n * 64 + off);
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mOcc[i] = 1'b0; mAddr[i] = '0; mKind[i] = '0;
    end
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqKind = '0;
    rspValid = 1'b0; rspTag = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk(reqReady == 1'b1, "R1 ready", reqReady, 1);
    chk(memValid == 1'b0, "R1 memValid", memValid, 0);
    chk(doneValid == 1'b0, "R1 doneValid", doneValid, 0);
    chk(rspErr == 1'b0, "R1 rspErr", rspErr, 0);
    @(negedge clk);

    // R2/R3: fill all slots with mixed kinds and offsets
    for (int i = 0; i < N; i++) step(1, blkAddr(i, i * 4), 2'(i), 0, 0, "R2");
    // R5: full table refuses
    step(1, blkAddr(20, 0), 2'd0, 0, 0, "R5");
    step(0, '0, 2'd0, 0, 0, "R5");

    // R6/R7: release out of order
    step(0, '0, 2'd0, 1, 3'd5, "R7");
    step(0, '0, 2'd0, 1, 3'd2, "R7");
    // R3: lowest free slot (2) reused before 5
    step(1, blkAddr(30, 8), 2'd2, 0, 0, "R3");
    step(1, blkAddr(31, 0), 2'd1, 0, 0, "R3");

    // R4/R10: same block, different offset and kind refused
    step(1, blkAddr(30, 60), 2'd0, 0, 0, "R10");
    // R4: write-prefetch against outstanding write (slot 1 holds block 1, kind 1)
    step(1, blkAddr(1, 12), 2'd3, 0, 0, "R4");
    // R4: write-prefetch against outstanding write-prefetch (slot 3, kind 3)
    step(1, blkAddr(3, 0), 2'd3, 0, 0, "R4");

    // R8: reply to an empty slot after freeing it
    step(0, '0, 2'd0, 1, 3'd0, "R6");
    step(0, '0, 2'd0, 1, 3'd0, "R8");
    // R8: table untouched: block 1 still conflicts, slot 0 still next free
    step(1, blkAddr(1, 0), 2'd0, 0, 0, "R8");
    step(1, blkAddr(40, 0), 2'd0, 0, 0, "R8");

    // R9: full table; release and request in the same cycle
    step(1, blkAddr(41, 0), 2'd0, 1, 3'd6, "R9");
    step(1, blkAddr(41, 0), 2'd0, 0, 0, "R9");
    // R10: block freed by a reply can be requested again
    step(0, '0, 2'd0, 1, 3'd4, "R10");
    step(1, blkAddr(4, 16), 2'd2, 0, 0, "R10");

    // drain in reverse order
    for (int i = N - 1; i >= 0; i--) step(0, '0, 2'd0, 1, 3'(i), "R7");
    step(1, blkAddr(50, 0), 2'd1, 0, 0, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule